// File: doc/BRIEF.md
# Fuse Shadow Register Array

This block keeps a bank of 32-bit shadow registers that mirror the words of a one-time-programmable fuse array, plus two lock bits per word. Software reaches the shadows through a request/response bus port. A read of a mapped shadow word returns the mirrored value. A write to a mapped shadow word replaces it, as long as the word is not write-locked and no reload is running. A reload request walks the fuse array through a simple read port. It copies each fuse word and its lock bits into the shadows, starting at word 0 and going upward.

Access faults set a sticky error flag. The faults are a write during a reload, a write to a write-locked word and a read of a read-locked word. While the flag is set, the block refuses every new bus request and every reload request until the controller pulses the clear input. A read-locked word never shows its contents: it reads as the fixed poison pattern 0xBADABADA.

The bus port uses valid/ready on both sides. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Its response sits in a single output register. `req_ready` is high when that register is empty or is being drained in the same cycle. A response held against a low `rsp_ready` keeps its data and error bit unchanged.

Top module: `fuse_shadow_array`

## Requirements
- R1: Shadow word i answers at byte offset 0x400 + 0x10*i for i < N_WORDS. A request at any other offset (below 0x400, not a multiple of 0x10 above it, or past the last word) is answered with data 0 and `rsp_err` 0, and a write there changes no shadow word.
- R2: After reset every shadow word reads 0, no word is locked, and `busy`, `error` and `rsp_valid` are low.
- R3: A `reload_req` pulse seen while `busy` and `error` are both low raises `busy` on the next cycle. The fuse port is then read at word addresses 0, 1, …, N_WORDS-1, in order, one word every STEP_CYC cycles. `fuse_rd` stays high for one cycle per word, and the fuse replies on `fuse_rdata`/`fuse_lock` in the cycle that follows.
- R4: `busy` stays high for (N_WORDS-1)*STEP_CYC + 2 cycles and falls on the cycle after the last shadow word is written. After that, each shadow word reads back the fuse value it was loaded with.
- R5: A write to a mapped word while `busy` is high leaves the shadow unchanged, sets `error` and is answered with `rsp_err` 1.
- R6: The lock bits come from `fuse_lock` during the reload: bit 1 is the write lock and bit 0 is the read lock. A write to a write-locked word is discarded, sets `error` and is answered with `rsp_err` 1.
- R7: A read of a read-locked word returns 0xBADABADA with `rsp_err` 1 and sets `error`.
- R8: While `error` is high, every request is answered with data 0 and `rsp_err` 1 and has no effect, and `reload_req` is ignored. `error` stays high until an `err_clr` pulse; if a new fault happens in the same cycle as the pulse, `error` stays high.
- R9: With `busy` and `error` low, a write to a mapped unlocked word stores `req_wdata`. It is answered with `rsp_err` 0, and a later read returns the stored value.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_data`/`rsp_err` hold steady. A response is cleared on the first cycle in which `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Bus request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset from block base |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | 32 | Read data (0 for writes and refused requests) |
| rsp_err | output | 1 | Request faulted or was refused |
| reload_req | input | 1 | Start a full shadow reload |
| err_clr | input | 1 | Clear the sticky error flag |
| busy | output | 1 | Reload in progress |
| error | output | 1 | Sticky access error flag |
| fuse_rd | output | 1 | Fuse word read strobe |
| fuse_addr | output | $clog2(N_WORDS) | Fuse word index |
| fuse_rdata | input | 32 | Fuse word, valid the cycle after `fuse_rd` |
| fuse_lock | input | 2 | Lock bits of that word: [1] write lock, [0] read lock |

## Verification
The bench builds the block with N_WORDS = 8 and STEP_CYC = 3. This makes a full reload only 23 busy cycles long, so the exact busy length and the full ascending fuse address order can be checked on every reload. The small array also lets the bench sweep every word for read-back, lock handling and write rejection. The locks are placed on a read-only-locked word, a write-only-locked word and a doubly locked word, so that every combination of lock bits meets both reads and writes. A write timed late in a reload, after word 0 has already been refreshed, shows that the rejected write did not reach the shadow.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam logic [31:0] POISON_WORD = 32'hBADA_BADA;
  localparam int unsigned MAP_BASE = 32'h400;
  localparam int unsigned MAP_STRIDE = 32'h10;

  // Bit 1 = write lock, bit 0 = read lock.
  typedef struct packed {
    logic wr_lock;
    logic rd_lock;
  } lock_t;
endpackage

// File: rtl/fsr_decode.sv
module fsr_decode #(
  parameter int N_WORDS = 128,
  parameter int ADDR_W  = 16,
  localparam int IW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IW-1:0]     idx
);
  import fsr_pkg::*;
  localparam int SH = $clog2(MAP_STRIDE);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(MAP_BASE);
  localparam logic [ADDR_W-1:0] NW_A = ADDR_W'(N_WORDS);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] word;

  always_comb begin
    rel  = addr - BASE_A;
    word = rel >> SH;
    hit  = (addr >= BASE_A) && (rel[SH-1:0] == '0) && (word < NW_A);
    idx  = word[IW-1:0];
  end
endmodule

// File: rtl/fsr_reload.sv
module fsr_reload #(
  parameter int N_WORDS  = 128,
  parameter int STEP_CYC = 4,
  localparam int IW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int CW = $clog2(STEP_CYC) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          fuse_rd,
  output logic [IW-1:0] fuse_addr,
  output logic          cap,
  output logic [IW-1:0] cap_idx
);
  localparam logic [IW-1:0] LAST = IW'(N_WORDS - 1);
  localparam logic [CW-1:0] STEP_END = CW'(STEP_CYC - 1);

  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        cnt_q  <= '0;
      end
    end else if (cnt_q == CW'(1) && idx_q == LAST) begin
      busy_q <= 1'b0;
    end else if (cnt_q == STEP_END) begin
      cnt_q <= '0;
      idx_q <= idx_q + IW'(1);
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign busy      = busy_q;
  assign fuse_rd   = busy_q && (cnt_q == '0);
  assign fuse_addr = idx_q;
  assign cap       = busy_q && (cnt_q == CW'(1));
  assign cap_idx   = idx_q;
endmodule

// File: rtl/fsr_port.sv
module fsr_port (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          hit,
  input  logic [31:0]   sh_data,
  input  fsr_pkg::lock_t lk,
  input  logic          busy,
  input  logic          err_clr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_data,
  output logic          rsp_err,
  output logic          wr_en,
  output logic          error
);
  import fsr_pkg::*;

  logic        rsp_valid_q, rsp_err_q, error_q;
  logic [31:0] rsp_data_q;
  logic        fire, bad_wr, bad_rd, fault;
  logic [31:0] rdata_n;

  always_comb begin
    req_ready = !rsp_valid_q || rsp_ready;
    fire      = req_valid && req_ready;
    bad_wr    = req_write && hit && (busy || lk.wr_lock);
    bad_rd    = !req_write && hit && lk.rd_lock;
    fault     = fire && !error_q && (bad_wr || bad_rd);
    wr_en     = fire && !error_q && req_write && hit && !busy && !lk.wr_lock;
    if (error_q || req_write || !hit) rdata_n = '0;
    else if (lk.rd_lock)              rdata_n = POISON_WORD;
    else                              rdata_n = sh_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_err_q   <= 1'b0;
      error_q     <= 1'b0;
    end else begin
      if (fire) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rdata_n;
        rsp_err_q   <= error_q || bad_wr || bad_rd;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
      if (fault)        error_q <= 1'b1;
      else if (err_clr) error_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_err   = rsp_err_q;
  assign error     = error_q;
endmodule

// File: rtl/fuse_shadow_array.sv
module fuse_shadow_array #(
  parameter int N_WORDS  = 128,
  parameter int STEP_CYC = 4,
  parameter int ADDR_W   = 16,
  localparam int IW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_err,
  input  logic              reload_req,
  input  logic              err_clr,
  output logic              busy,
  output logic              error,
  output logic              fuse_rd,
  output logic [IW-1:0]     fuse_addr,
  input  logic [31:0]       fuse_rdata,
  input  logic [1:0]        fuse_lock
);
  import fsr_pkg::*;

  logic [31:0]   sh_mem [N_WORDS];
  lock_t         lk_mem [N_WORDS];
  logic          hit, wr_en, cap;
  logic [IW-1:0] idx, cap_idx;

  fsr_decode #(.N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .hit(hit), .idx(idx)
  );

  fsr_reload #(.N_WORDS(N_WORDS), .STEP_CYC(STEP_CYC)) u_rld (
    .clk(clk), .rst_n(rst_n), .start(reload_req && !error), .busy(busy),
    .fuse_rd(fuse_rd), .fuse_addr(fuse_addr), .cap(cap), .cap_idx(cap_idx)
  );

  fsr_port u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .hit(hit), .sh_data(sh_mem[idx]), .lk(lk_mem[idx]),
    .busy(busy), .err_clr(err_clr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .wr_en(wr_en), .error(error)
  );

  // Reload capture and bus write never coincide: writes are rejected while busy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WORDS; i++) begin
        sh_mem[i] <= '0;
        lk_mem[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (cap && cap_idx == IW'(i)) begin
          sh_mem[i] <= fuse_rdata;
          lk_mem[i] <= lock_t'(fuse_lock);
        end else if (wr_en && idx == IW'(i)) begin
          sh_mem[i] <= req_wdata;
        end
      end
    end
  end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int N_WORDS = 128,
  localparam int IW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [31:0]   rsp_data,
  input logic          rsp_err,
  input logic          reload_req,
  input logic          err_clr,
  input logic          busy,
  input logic          error,
  input logic          fuse_rd,
  input logic [IW-1:0] fuse_addr
);
  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reload_req) && !$past(error));

  p_fuse_in_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd |-> busy && (int'(fuse_addr) < N_WORDS));

  p_capture_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd |=> busy && !fuse_rd);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    error && !err_clr |=> error);

  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && error |=> rsp_valid && rsp_err && rsp_data == 32'h0);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));

  p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

bind fuse_shadow_array fsr_checker #(.N_WORDS(N_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_err(rsp_err), .reload_req(reload_req), .err_clr(err_clr),
  .busy(busy), .error(error), .fuse_rd(fuse_rd), .fuse_addr(fuse_addr)
);

// File: tb/tb_fuse_shadow_array.sv
module tb_fuse_shadow_array;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int STEP = 3;
  localparam int AW = 16;
  localparam int IW = $clog2(NW);
  localparam logic [31:0] POISON = 32'hBADA_BADA;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1, reload_req = 0, err_clr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, busy, error, fuse_rd;
  logic [31:0] rsp_data;
  logic [IW-1:0] fuse_addr;
  logic [31:0] fuse_rdata = '0;
  logic [1:0] fuse_lock = '0;

  int checks = 0, failures = 0, exp_faddr = 0;
  logic [31:0] shadow_exp [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_shadow_array #(.N_WORDS(NW), .STEP_CYC(STEP), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .reload_req(reload_req), .err_clr(err_clr),
    .busy(busy), .error(error), .fuse_rd(fuse_rd), .fuse_addr(fuse_addr),
    .fuse_rdata(fuse_rdata), .fuse_lock(fuse_lock)
  );

  function automatic logic [31:0] fval(int i);
    return 32'h5A00_0000 + i * 32'h0001_0111;
  endfunction
  // word 2: read lock, word 5: write lock, word 6: both
  function automatic logic [1:0] lval(int i);
    return (i == 2) ? 2'b01 : (i == 5) ? 2'b10 : (i == 6) ? 2'b11 : 2'b00;
  endfunction
  function automatic logic [AW-1:0] waddr(int i);
    return AW'(32'h400 + 32'h10 * i);
  endfunction

  // Behavioural fuse array: one-cycle read latency.
  always @(posedge clk) if (fuse_rd) begin
    fuse_rdata <= fval(int'(fuse_addr));
    fuse_lock  <= lval(int'(fuse_addr));
  end

  // R3: ascending fuse address order
  always @(posedge clk) if (rst_n && fuse_rd) begin
    checks++;
    if (int'(fuse_addr) != exp_faddr) begin
      failures++;
      $display("FAIL R3 fuse_addr act=%0d exp=%0d", fuse_addr, exp_faddr);
    end
    exp_faddr++;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid, "R10 rsp_valid after request", {31'b0, rsp_valid}, 32'h1);
    rd = rsp_data; er = rsp_err;
  endtask

  task automatic clear_err;
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic do_reload(output int cyc);
    @(negedge clk);
    exp_faddr = 0;
    reload_req = 1;
    @(negedge clk);
    reload_req = 0;
    cyc = 0;
    while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic e;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk(!busy && !error && !rsp_valid && req_ready, "R2 reset flags",
        {28'b0, busy, error, rsp_valid, req_ready}, 32'h1);
    for (int i = 0; i < NW; i++) begin
      access(0, waddr(i), 0, d, e);
      chk(d == 0 && !e, "R2 shadow zero after reset", d, 32'h0);
    end
    // R9 write before reload (no locks yet)
    access(1, waddr(3), 32'h1234_5678, d, e);
    chk(!e, "R9 write accepted", {31'b0, e}, 0);
    access(0, waddr(3), 0, d, e);
    chk(d == 32'h1234_5678 && !e, "R9 readback", d, 32'h1234_5678);

    // R3/R4 reload
    do_reload(cyc);
    chk(cyc == (NW - 1) * STEP + 2, "R4 busy length", cyc, (NW - 1) * STEP + 2);
    chk(exp_faddr == NW, "R3 fuse word count", exp_faddr, NW);
    for (int i = 0; i < NW; i++) shadow_exp[i] = fval(i);
    for (int i = 0; i < NW; i++) begin
      access(0, waddr(i), 0, d, e);
      if (lval(i)[0]) begin
        chk(d == POISON && e, "R7 read-locked poison", d, POISON);
        chk(error, "R7 error set", {31'b0, error}, 1);
        clear_err();
      end else begin
        chk(d == fval(i) && !e, "R4 reloaded value", d, fval(i));
      end
    end

    // R6/R9 write sweep
    for (int i = 0; i < NW; i++) begin
      access(1, waddr(i), ~fval(i), d, e);
      if (lval(i)[1]) begin
        chk(e && error, "R6 write-locked rejected", {31'b0, e}, 1);
        clear_err();
      end else begin
        chk(!e, "R9 unlocked write ok", {31'b0, e}, 0);
        shadow_exp[i] = ~fval(i);
      end
    end
    for (int i = 0; i < NW; i++) begin
      access(0, waddr(i), 0, d, e);
      if (lval(i)[0]) begin
        chk(d == POISON && e, "R7 poison after write", d, POISON);
        clear_err();
      end else begin
        chk(d == shadow_exp[i] && !e, "R6 R9 readback", d, shadow_exp[i]);
      end
    end

    // R1 unmapped offsets
    access(0, AW'(32'h404), 0, d, e);
    chk(d == 0 && !e, "R1 misaligned read", d, 0);
    access(0, AW'(32'h3F0), 0, d, e);
    chk(d == 0 && !e, "R1 below base read", d, 0);
    access(0, waddr(NW), 0, d, e);
    chk(d == 0 && !e, "R1 past end read", d, 0);
    access(1, AW'(32'h408), 32'hFFFF_FFFF, d, e);
    chk(!e && !error, "R1 unmapped write no error", {31'b0, e}, 0);
    access(0, waddr(0), 0, d, e);
    chk(d == shadow_exp[0], "R1 word0 untouched", d, shadow_exp[0]);

    // R5 write during reload (after word 0 refreshed)
    @(negedge clk);
    exp_faddr = 0;
    reload_req = 1;
    @(negedge clk);
    reload_req = 0;
    repeat (12) @(negedge clk);
    access(1, waddr(0), 32'hDEAD_BEEF, d, e);
    chk(e, "R5 write during reload rsp_err", {31'b0, e}, 1);
    while (busy) @(negedge clk);
    chk(error, "R5 error after busy write", {31'b0, error}, 1);
    clear_err();
    access(0, waddr(0), 0, d, e);
    chk(d == fval(0) && !e, "R5 shadow unchanged", d, fval(0));

    // R8 refusal while error set
    access(0, waddr(2), 0, d, e);
    chk(error, "R8 error raised", {31'b0, error}, 1);
    access(0, waddr(1), 0, d, e);
    chk(d == 0 && e, "R8 read refused", d, 0);
    access(1, waddr(1), 32'h0BAD_0BAD, d, e);
    chk(e, "R8 write refused", {31'b0, e}, 1);
    @(negedge clk); reload_req = 1;
    @(negedge clk); reload_req = 0;
    chk(!busy, "R8 reload ignored", {31'b0, busy}, 0);
    @(negedge clk);
    chk(error, "R8 error sticky", {31'b0, error}, 1);
    clear_err();
    chk(!error, "R8 err_clr clears", {31'b0, error}, 0);
    access(0, waddr(1), 0, d, e);
    chk(d == fval(1) && !e, "R8 word1 untouched", d, fval(1));

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = waddr(3);
    @(negedge clk);
    req_valid = 0;
    d = rsp_data;
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid && !req_ready && rsp_data == d, "R10 hold under back-pressure", rsp_data, d);
      @(negedge clk);
    end
    chk(d == fval(3), "R10 held data", d, fval(3));
    rsp_ready = 1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10 drained", {31'b0, rsp_valid}, 0);

    summary();
  end
endmodule